// File: doc/BRIEF.md
# Multi-Digit Decimal Adder

This block adds two unsigned packed-decimal operands of `N` digits each (default 3) together with a carry in. It returns an `N`-digit decimal sum and a decimal carry out. Each digit position has its own stage. A stage adds its two 4-bit digits and the carry arriving from the position below as plain binary, which gives a 5-bit result. It then decides whether that result needs decimal correction. The correction decision also serves as the carry into the next position up, so the chain runs from digit 0 (least significant nibble) to digit `N-1`.

The operands enter on a valid/ready interface and the result leaves on one. Parameter `REG_OUT` selects between two forms. With `REG_OUT = 0` the adder is purely combinational: the output handshake passes straight through to the input side, so `in_ready` follows `out_ready` and `out_valid` follows `in_valid`. With `REG_OUT = 1` a single output register holds the result. That register accepts a new word whenever it is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result and `out_valid` hold steady and `in_ready` is low. Operands whose digits exceed 9 are outside the intended use.

Top module: `bcd_multi_adder`

## Requirements
- R1: In each digit stage, when the 5-bit binary sum of the two digits and the incoming carry is 9 or less, the output digit equals that sum and no carry leaves the stage.
- R2: When a stage's binary sum lies between 10 and 19, the stage adds 6 to the sum's low four bits and outputs those four bits of the result. For example, 7 + 6 gives digit 3, and 5 + 3 gives digit 8 with no correction.
- R3: The carry into digit position k+1 equals the correction flag of position k. Digit k occupies bits [4k+3:4k] of `in_a`, `in_b` and `out_sum`.
- R4: `out_carry` equals the correction flag of the most significant digit stage.
- R5: For valid decimal operands, the decimal value of `out_sum` plus `out_carry`·10^N equals value(A) + value(B) + `in_cin`. For example, 247 + 538 with carry in 0 gives 785 with carry out 0.
- R6: With `REG_OUT = 0`, `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle, and the sum is available in the same cycle.
- R7: With `REG_OUT = 1`, a word accepted on a clock edge (`in_valid` and `in_ready` both high) appears on the outputs with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, the outputs stay stable and `in_ready` is low. When the register is empty, `in_ready` is high.
- R8: After reset (`rst_n` low), `out_valid` is low.
- R9: Whenever `out_valid` is high for valid decimal operands, every digit of `out_sum` is 9 or less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only when `REG_OUT = 1` |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand word is valid |
| in_ready | output | 1 | Adder can accept the operand word |
| in_a | input | 4·N | First operand, packed decimal, digit 0 in low nibble |
| in_b | input | 4·N | Second operand, same packing |
| in_cin | input | 1 | Carry into digit 0 |
| out_valid | output | 1 | Result word is valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_sum | output | 4·N | Decimal sum digits |
| out_carry | output | 1 | Carry out of digit N-1 |

## Verification
A stage that misjudges the 10-to-19 window shows up at once as a digit above 9 or a digit off by six. Its neighbour then reads one too low or one too high, because the carry comes from the same flag. In the combinational form these errors appear in the same cycle as the operands. In the registered form they appear one edge after acceptance. A broken hold register shows up as output that changes, or as `in_ready` rising, during a stall, on the first cycle the stall lasts.

// File: rtl/bcd_adder_pkg.sv
package bcd_adder_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DEC_FIX = 4'd6;
  typedef logic [DIGIT_W-1:0] dec_digit_t;
endpackage

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
  import bcd_adder_pkg::*;
(
  input  dec_digit_t dig_a,
  input  dec_digit_t dig_b,
  input  logic       carry_in,
  output dec_digit_t dig_sum,
  output logic       carry_out
);
  logic [DIGIT_W:0] raw_sum;
  logic             fix_flag;

  always_comb begin
    raw_sum  = {1'b0, dig_a} + {1'b0, dig_b} + {{DIGIT_W{1'b0}}, carry_in};
    // binary sums 10..19 need the decimal correction
    fix_flag = raw_sum[4] | (raw_sum[3] & (raw_sum[2] | raw_sum[1]));
    dig_sum  = fix_flag ? (raw_sum[DIGIT_W-1:0] + DEC_FIX) : raw_sum[DIGIT_W-1:0];
    carry_out = fix_flag;
  end
endmodule

// File: rtl/bcd_carry_chain.sv
module bcd_carry_chain
  import bcd_adder_pkg::*;
#(
  parameter int unsigned N = 3
)(
  input  logic [DIGIT_W*N-1:0] op_a,
  input  logic [DIGIT_W*N-1:0] op_b,
  input  logic                 cin,
  output logic [DIGIT_W*N-1:0] sum,
  output logic                 cout
);
  logic [N:0] link;

  assign link[0] = cin;

  for (genvar k = 0; k < N; k++) begin : g_digit
    bcd_digit_stage u_stage (
      .dig_a     (op_a[DIGIT_W*k +: DIGIT_W]),
      .dig_b     (op_b[DIGIT_W*k +: DIGIT_W]),
      .carry_in  (link[k]),
      .dig_sum   (sum[DIGIT_W*k +: DIGIT_W]),
      .carry_out (link[k+1])
    );
  end

  assign cout = link[N];
endmodule

// File: rtl/bcd_out_stage.sv
module bcd_out_stage #(
  parameter int unsigned W       = 13,
  parameter bit          REG_OUT = 1'b1
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  if (REG_OUT) begin : g_reg
    logic         full_q;
    logic [W-1:0] data_q;

    assign up_ready = !full_q || dn_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        full_q <= 1'b0;
      else if (up_ready) full_q <= up_valid;
    end

    always_ff @(posedge clk) begin
      if (up_valid && up_ready) data_q <= up_data;
    end

    assign dn_valid = full_q;
    assign dn_data  = data_q;
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign up_ready = dn_ready;
    assign dn_valid = up_valid;
    assign dn_data  = up_data;
  end
endmodule

// File: rtl/bcd_multi_adder.sv
module bcd_multi_adder
  import bcd_adder_pkg::*;
#(
  parameter int unsigned N       = 3,
  parameter bit          REG_OUT = 1'b1
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DIGIT_W*N-1:0] in_a,
  input  logic [DIGIT_W*N-1:0] in_b,
  input  logic                 in_cin,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DIGIT_W*N-1:0] out_sum,
  output logic                 out_carry
);
  localparam int unsigned SUM_W = DIGIT_W * N;
  localparam int unsigned PAY_W = SUM_W + 1;

  logic [SUM_W-1:0] chain_sum;
  logic             chain_cout;
  logic [PAY_W-1:0] pay_out;

  bcd_carry_chain #(.N(N)) u_chain (
    .op_a (in_a),
    .op_b (in_b),
    .cin  (in_cin),
    .sum  (chain_sum),
    .cout (chain_cout)
  );

  bcd_out_stage #(.W(PAY_W), .REG_OUT(REG_OUT)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  ({chain_cout, chain_sum}),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (pay_out)
  );

  assign out_sum   = pay_out[SUM_W-1:0];
  assign out_carry = pay_out[SUM_W];
endmodule

// File: rtl/bcd_multi_adder_chk.sv
module bcd_multi_adder_chk #(
  parameter int unsigned N       = 3,
  parameter bit          REG_OUT = 1'b1
)(
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [4*N-1:0] in_a,
  input logic [4*N-1:0] in_b,
  input logic           in_cin,
  input logic           out_valid,
  input logic           out_ready,
  input logic [4*N-1:0] out_sum,
  input logic           out_carry
);
  function automatic longint dec_of(input logic [4*N-1:0] v);
    longint acc = 0;
    for (int k = N - 1; k >= 0; k--) acc = acc * 10 + longint'(v[4*k +: 4]);
    return acc;
  endfunction

  function automatic bit digits_ok(input logic [4*N-1:0] v);
    bit ok = 1'b1;
    for (int k = 0; k < N; k++) if (v[4*k +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  longint scale;
  longint in_total;
  longint out_total;
  always_comb begin
    scale = 1;
    for (int k = 0; k < N; k++) scale = scale * 10;
    in_total  = dec_of(in_a) + dec_of(in_b) + longint'(in_cin);
    out_total = dec_of(out_sum) + (out_carry ? scale : 0);
  end

  a_r9_digits_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> digits_ok(out_sum));

  if (REG_OUT) begin : g_reg_chk
    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && out_total == $past(in_total)));
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_carry)));
    a_r7_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);
  end else begin : g_comb_chk
    a_r5_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (out_valid && out_total == in_total));
  end
endmodule

bind bcd_multi_adder bcd_multi_adder_chk #(.N(N), .REG_OUT(REG_OUT)) chk_i (.*);

// File: tb/bcd_multi_adder_tb_top.sv
`timescale 1ns/1ps
module bcd_multi_adder_tb_top;
  localparam int N  = 3;
  localparam int W  = 4 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic in_cin = 1'b0;
  logic in_ready, out_valid, out_carry;
  logic [W-1:0] out_sum;
  logic c_in_ready, c_out_valid, c_out_carry;
  logic [W-1:0] c_out_sum;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  bcd_multi_adder #(.N(N), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_cin(in_cin), .out_valid(out_valid),
    .out_ready(out_ready), .out_sum(out_sum), .out_carry(out_carry));

  bcd_multi_adder #(.N(N), .REG_OUT(1'b0)) dut_c (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(c_in_ready),
    .in_a(in_a), .in_b(in_b), .in_cin(in_cin), .out_valid(c_out_valid),
    .out_ready(1'b1), .out_sum(c_out_sum), .out_carry(c_out_carry));

  function automatic int dec_of(input logic [W-1:0] v);
    int acc = 0;
    for (int k = N - 1; k >= 0; k--) acc = acc * 10 + int'(v[4*k +: 4]);
    return acc;
  endfunction

  function automatic logic [W-1:0] to_dec(input int v);
    logic [W-1:0] r = '0;
    int t = v;
    for (int k = 0; k < N; k++) begin
      r[4*k +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic logic [W-1:0] rand_dec();
    logic [W-1:0] r = '0;
    for (int k = 0; k < N; k++) r[4*k +: 4] = 4'($urandom % 10);
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one transaction through both instances; stall = cycles with out_ready low
  task automatic txn(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic c, input int stall);
    int total;
    logic [W-1:0] e_sum;
    logic e_c;
    total = dec_of(a) + dec_of(b) + int'(c);
    e_sum = to_dec(total % 1000);
    e_c   = (total >= 1000);
    @(negedge clk);
    in_a = a; in_b = b; in_cin = c; in_valid = 1'b1; out_ready = 1'b0;
    #1;
    check({tag, " R6 comb valid/ready"}, {c_out_valid, c_in_ready}, 2'b11);
    check({tag, " R6 comb sum"}, {c_out_carry, c_out_sum}, {e_c, e_sum});
    check("R7 ready when empty", in_ready, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check("R6 comb valid drops", c_out_valid, 1'b0);
    check({tag, " R7 registered sum"}, {out_valid, out_carry, out_sum}, {1'b1, e_c, e_sum});
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check("R7 hold during stall", {out_valid, in_ready, out_carry, out_sum},
            {1'b1, 1'b0, e_c, e_sum});
    end
    out_ready = 1'b1;
    @(negedge clk);
    check("R7 drained", out_valid, 1'b0);
    out_ready = 1'b0;
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R8 reset out_valid", out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle after reset", {out_valid, in_ready}, 2'b01);

    // directed examples
    txn("R2 5+3", 12'h005, 12'h003, 1'b0, 0);
    txn("R2 7+6", 12'h007, 12'h006, 1'b0, 1);
    txn("R5 247+538", 12'h247, 12'h538, 1'b0, 2);
    txn("R4 999+999+1", 12'h999, 12'h999, 1'b1, 0);
    txn("R4 500+499", 12'h500, 12'h499, 1'b0, 0);
    txn("R3 ripple 999+000+1", 12'h999, 12'h000, 1'b1, 1);

    // every digit pair at digit 0 and at the top digit, both carry values
    for (int da = 0; da < 10; da++)
      for (int db = 0; db < 10; db++)
        for (int c = 0; c < 2; c++) begin
          if (da + db + c <= 9) txn("R1 low digit", W'(da), W'(db), 1'(c), 0);
          else txn("R2 R3 low digit", W'(da), W'(db), 1'(c), 0);
          txn("R4 top digit", W'(da) << 8, W'(db) << 8, 1'(c), 0);
        end

    // random operands with random stalls
    for (int i = 0; i < 1500; i++)
      txn("R5 R9 random", rand_dec(), rand_dec(), 1'($urandom % 2), int'($urandom % 3));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule